// File: doc/BRIEF.md
# Four-Channel Triggered DMA Engine

The engine owns four independent transfer channels. Each channel keeps a 32-bit source address, a 32-bit destination address, a 16-bit remaining-unit count and an 8-bit mode byte, and software reaches all of them through a byte-addressed control port that checks the access size. Each pulse on a channel's trigger line asks for exactly one unit of work. Depending on the mode, that unit is a read of one byte, 16-bit word or 32-bit long from the source over a request/ready memory bus, followed by a write of the same value to the destination. The mode also sets how the addresses move afterwards: one of them steps up or down by the unit size, both stay fixed, or the bus is left idle and the source register counts up by one.

Every serviced trigger decrements the count. When the count reaches zero, the engine sends a one-cycle interrupt request and then issues a byte write of zero that clears the channel's trigger vector. Pending triggers are latched and granted in fixed priority, with the lowest channel index first. A register write aimed at the channel being serviced is held back and applied once that unit's address and count updates have been written.

Top module: `dma4_engine`

## Requirements
- R1: After reset every source, destination, count and mode register reads as zero, and `mem_req_o` and `irq_o` are low.
- R2: The control map uses the following offsets and sizes. Source n is at 0x00+4n and destination n is at 0x10+4n, both accessed with size 2 (long). Count n is at 0x20+4n with size 1 (word). Mode n is at 0x22+4n with size 0 (byte). A read at any other offset, or with any other size, returns zero. A write at any other offset, or with any other size, changes nothing.
- R3: Size codes in the mode byte are 0 byte, 1 word and 2 long. In a copying unit, the engine reads the source address at that size, then writes the returned 32-bit value unchanged to the destination address at the same size.
- R4: Mode field (bits [4:2]) 0 copies one unit, then adds the step (1, 2 or 4 for size 0, 1 or 2) to the destination. Mode 1 copies one unit, then subtracts the step from the destination. The source address does not change.
- R5: Mode 2 copies one unit, then adds the step to the source. Mode 3 copies one unit, then subtracts the step from the source. The destination address does not change.
- R6: Mode 4 copies one unit and leaves both addresses unchanged. Mode 5 issues no bus cycle and adds one to the source. Size code 3, and modes 6 and 7, issue no bus cycle and change no address. In every case the count drops by one.
- R7: A trigger on a channel whose count is zero produces no bus cycle and no interrupt, and leaves every register of that channel unchanged.
- R8: A unit that brings the count to zero raises `irq_o` for one cycle, with `irq_vec_o` = 14 + channel and `irq_lvl_o` = 7. In the next cycle the engine requests a byte write of data 0 to address 0x7C + channel. That write completes before the engine starts another unit.
- R9: Triggers are latched until they are served. Among pending channels, the lowest index is started first.
- R10: A control write to the channel being serviced takes effect after that unit's updates and overrides them. The unit in flight still uses the addresses it started with.
- R11: Once `mem_req_o` is raised, it stays high with stable address, size, write enable and write data until the cycle in which `mem_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_addr_i | input | 8 | Control byte offset |
| cfg_size_i | input | 2 | Control access size (0 byte, 1 word, 2 long) |
| cfg_wdata_i | input | 32 | Control write data, right-aligned |
| cfg_rdata_o | output | 32 | Control read data for cfg_addr_i/cfg_size_i, zero-extended |
| trig_i | input | 4 | Per-channel trigger pulses |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | Bus write enable |
| mem_size_o | output | 2 | Bus access size |
| mem_addr_o | output | 32 | Bus address |
| mem_wdata_o | output | 32 | Bus write data |
| mem_rdata_i | input | 32 | Bus read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Bus completion |
| irq_o | output | 1 | Terminal-count interrupt pulse |
| irq_vec_o | output | 5 | Interrupt vector number |
| irq_lvl_o | output | 3 | Interrupt priority level |

## Verification
If an address register is stepped wrongly, the error appears on `mem_addr_o` at that channel's next copy, and also on the control read port as soon as the unit ends. If the count is tracked wrongly, the channel-clear write and interrupt arrive early, late or never, and the channel's count read shows the wrong value immediately. If arbitration or the trigger latch is wrong, the bus cycles of different channels come out in the wrong order or some are missing. If the deferred-write path is wrong, the in-flight cycle uses the new address, or the written value reads back already altered by the update.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int unsigned NCH = 4;
  localparam int unsigned CHW = $clog2(NCH);
  localparam int unsigned AW  = 32;
  localparam int unsigned DW  = 32;
  localparam int unsigned CW  = 16;
  localparam int unsigned MW  = 8;
  localparam int unsigned VW  = 5;

  localparam logic [VW-1:0] IRQ_BASE = 5'd14;
  localparam logic [2:0]    IRQ_LVL  = 3'd7;
  localparam logic [AW-1:0] CLR_BASE = 32'h0000_007C;

  localparam logic [1:0] SZ_B    = 2'd0;
  localparam logic [1:0] SZ_W    = 2'd1;
  localparam logic [1:0] SZ_L    = 2'd2;
  localparam logic [1:0] SZ_NONE = 2'd3;

  typedef enum logic [2:0] {K_NONE, K_SRC, K_DST, K_CNT, K_MODE} reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [CHW-1:0]   ch;
    logic [DW-1:0]    data;
  } reg_wr_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_WR, ST_UPD, ST_CLR} seq_st_e;

  // blk = offset[7:4], lo = offset[1:0]
  function automatic reg_kind_e reg_decode(input logic [3:0] blk, input logic [1:0] lo,
                                           input logic [1:0] sz);
    reg_kind_e k;
    k = K_NONE;
    case (blk)
      4'h0: if (lo == 2'd0 && sz == SZ_L) k = K_SRC;
      4'h1: if (lo == 2'd0 && sz == SZ_L) k = K_DST;
      4'h2: begin
        if (lo == 2'd0 && sz == SZ_W) k = K_CNT;
        else if (lo == 2'd2 && sz == SZ_B) k = K_MODE;
      end
      default: k = K_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
#(
  parameter int unsigned N = NCH
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [7:0]     cfg_addr_i,
  input  logic [1:0]     cfg_size_i,
  input  logic [DW-1:0]  cfg_wdata_i,
  output logic [DW-1:0]  cfg_rdata_o,
  input  logic           busy_i,
  input  logic [CHW-1:0] busy_ch_i,
  input  logic           upd_i,
  input  logic [CHW-1:0] upd_ch_i,
  input  logic [AW-1:0]  upd_src_i,
  input  logic [AW-1:0]  upd_dst_i,
  input  logic [CW-1:0]  upd_cnt_i,
  output logic [AW-1:0]  src_o  [N],
  output logic [AW-1:0]  dst_o  [N],
  output logic [CW-1:0]  cnt_o  [N],
  output logic [MW-1:0]  mode_o [N]
);
  reg_wr_t   wr, buf_q;
  logic      wr_v, hold, buf_v;
  reg_kind_e rk;
  logic [CHW-1:0] rch;

  assign wr.kind = reg_decode(cfg_addr_i[7:4], cfg_addr_i[1:0], cfg_size_i);
  assign wr.ch   = cfg_addr_i[2 +: CHW];
  assign wr.data = cfg_wdata_i;
  assign wr_v    = cfg_we_i && (wr.kind != K_NONE);
  // write to the channel in flight waits for its update cycle
  assign hold    = wr_v && busy_i && (busy_ch_i == wr.ch) && !upd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_v <= 1'b0;
      buf_q <= '0;
    end else if (hold) begin
      buf_v <= 1'b1;
      buf_q <= wr;
    end else if (upd_i) begin
      buf_v <= 1'b0;
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_ch
    logic [AW-1:0] s_q, d_q;
    logic [CW-1:0] n_q;
    logic [MW-1:0] m_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_q <= '0;
        d_q <= '0;
        n_q <= '0;
        m_q <= '0;
      end else begin
        if (upd_i && upd_ch_i == CHW'(c)) begin
          s_q <= upd_src_i;
          d_q <= upd_dst_i;
          n_q <= upd_cnt_i;
        end
        if (upd_i && buf_v && buf_q.ch == CHW'(c)) begin
          case (buf_q.kind)
            K_SRC:   s_q <= buf_q.data;
            K_DST:   d_q <= buf_q.data;
            K_CNT:   n_q <= buf_q.data[CW-1:0];
            K_MODE:  m_q <= buf_q.data[MW-1:0];
            default: ;
          endcase
        end
        if (wr_v && !hold && wr.ch == CHW'(c)) begin
          case (wr.kind)
            K_SRC:   s_q <= wr.data;
            K_DST:   d_q <= wr.data;
            K_CNT:   n_q <= wr.data[CW-1:0];
            K_MODE:  m_q <= wr.data[MW-1:0];
            default: ;
          endcase
        end
      end
    end

    assign src_o[c]  = s_q;
    assign dst_o[c]  = d_q;
    assign cnt_o[c]  = n_q;
    assign mode_o[c] = m_q;
  end

  assign rk  = reg_decode(cfg_addr_i[7:4], cfg_addr_i[1:0], cfg_size_i);
  assign rch = cfg_addr_i[2 +: CHW];

  always_comb begin
    case (rk)
      K_SRC:   cfg_rdata_o = src_o[rch];
      K_DST:   cfg_rdata_o = dst_o[rch];
      K_CNT:   cfg_rdata_o = DW'(cnt_o[rch]);
      K_MODE:  cfg_rdata_o = DW'(mode_o[rch]);
      default: cfg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb
  import dma4_pkg::*;
#(
  parameter int unsigned N = NCH
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   trig_i,
  input  logic           take_i,
  output logic           pend_any_o,
  output logic [CHW-1:0] sel_o
);
  logic [N-1:0] pend_q, clr;

  always_comb begin
    sel_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (pend_q[i]) sel_o = CHW'(i);
    end
  end

  assign pend_any_o = |pend_q;
  assign clr = take_i ? ({{(N-1){1'b0}}, 1'b1} << sel_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | trig_i;
  end
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pend_any_i,
  input  logic [CHW-1:0] sel_i,
  input  logic [AW-1:0]  src_i,
  input  logic [AW-1:0]  dst_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic [4:0]     mode_i,
  output logic           take_o,
  output logic           busy_o,
  output logic [CHW-1:0] busy_ch_o,
  output logic           upd_o,
  output logic [CHW-1:0] upd_ch_o,
  output logic [AW-1:0]  upd_src_o,
  output logic [AW-1:0]  upd_dst_o,
  output logic [CW-1:0]  upd_cnt_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [1:0]     mem_size_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ready_i,
  output logic           irq_o,
  output logic [VW-1:0]  irq_vec_o,
  output logic [2:0]     irq_lvl_o
);
  seq_st_e        st_q;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  src_q, dst_q, step;
  logic [CW-1:0]  cnt_q, cnt_nx;
  logic [2:0]     md_q;
  logic [1:0]     sz_q;
  logic [DW-1:0]  dat_q;
  logic           start, needs_bus, done;

  assign take_o    = (st_q == ST_IDLE) && pend_any_i;
  assign start     = take_o && (cnt_i != '0);
  assign needs_bus = (mode_i[4:2] <= 3'd4) && (mode_i[1:0] != SZ_NONE);
  assign done      = mem_req_o && mem_ready_i;
  assign step      = (sz_q == SZ_NONE) ? '0 : (AW'(1) << sz_q);
  assign cnt_nx    = cnt_q - CW'(1);

  assign busy_o    = start || (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_UPD);
  assign busy_ch_o = (st_q == ST_IDLE) ? sel_i : ch_q;

  assign upd_o     = (st_q == ST_UPD);
  assign upd_ch_o  = ch_q;
  assign upd_cnt_o = cnt_nx;

  always_comb begin
    upd_src_o = src_q;
    upd_dst_o = dst_q;
    case (md_q)
      3'd0:    upd_dst_o = dst_q + step;
      3'd1:    upd_dst_o = dst_q - step;
      3'd2:    upd_src_o = src_q + step;
      3'd3:    upd_src_o = src_q - step;
      3'd5:    upd_src_o = src_q + AW'(1);
      default: ;
    endcase
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_size_o  = sz_q;
    mem_addr_o  = src_q;
    mem_wdata_o = dat_q;
    case (st_q)
      ST_RD: mem_req_o = 1'b1;
      ST_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = dst_q;
      end
      ST_CLR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_size_o  = SZ_B;
        mem_addr_o  = CLR_BASE + AW'(ch_q);
        mem_wdata_o = '0;
      end
      default: ;
    endcase
  end

  assign irq_o     = (st_q == ST_UPD) && (cnt_nx == '0);
  assign irq_vec_o = IRQ_BASE + VW'(ch_q);
  assign irq_lvl_o = IRQ_LVL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ch_q  <= '0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      md_q  <= '0;
      sz_q  <= '0;
      dat_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          ch_q  <= sel_i;
          src_q <= src_i;
          dst_q <= dst_i;
          cnt_q <= cnt_i;
          md_q  <= mode_i[4:2];
          sz_q  <= mode_i[1:0];
          st_q  <= needs_bus ? ST_RD : ST_UPD;
        end
        ST_RD: if (done) begin
          dat_q <= mem_rdata_i;
          st_q  <= ST_WR;
        end
        ST_WR:   if (done) st_q <= ST_UPD;
        ST_UPD:  st_q <= (cnt_nx == '0) ? ST_CLR : ST_IDLE;
        ST_CLR:  if (done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [1:0]        cfg_size_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  output logic [DW-1:0]     cfg_rdata_o,
  input  logic [NCH-1:0]    trig_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_size_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              irq_o,
  output logic [VW-1:0]     irq_vec_o,
  output logic [2:0]        irq_lvl_o
);
  logic [AW-1:0]  src_w  [NCH];
  logic [AW-1:0]  dst_w  [NCH];
  logic [CW-1:0]  cnt_w  [NCH];
  logic [MW-1:0]  mode_w [NCH];
  logic           pend_any, take, busy, upd;
  logic [CHW-1:0] sel, busy_ch, upd_ch;
  logic [AW-1:0]  upd_src, upd_dst;
  logic [CW-1:0]  upd_cnt;
  logic [MW-1:0]  sel_mode;

  assign sel_mode = mode_w[sel];

  dma4_regs #(.N(NCH)) u_regs (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_addr_i, .cfg_size_i, .cfg_wdata_i, .cfg_rdata_o,
    .busy_i(busy), .busy_ch_i(busy_ch),
    .upd_i(upd), .upd_ch_i(upd_ch), .upd_src_i(upd_src), .upd_dst_i(upd_dst),
    .upd_cnt_i(upd_cnt),
    .src_o(src_w), .dst_o(dst_w), .cnt_o(cnt_w), .mode_o(mode_w)
  );

  dma4_arb #(.N(NCH)) u_arb (
    .clk_i, .rst_ni, .trig_i, .take_i(take), .pend_any_o(pend_any), .sel_o(sel)
  );

  dma4_seq u_seq (
    .clk_i, .rst_ni,
    .pend_any_i(pend_any), .sel_i(sel),
    .src_i(src_w[sel]), .dst_i(dst_w[sel]), .cnt_i(cnt_w[sel]), .mode_i(sel_mode[4:0]),
    .take_o(take), .busy_o(busy), .busy_ch_o(busy_ch),
    .upd_o(upd), .upd_ch_o(upd_ch), .upd_src_o(upd_src), .upd_dst_o(upd_dst),
    .upd_cnt_o(upd_cnt),
    .mem_req_o, .mem_we_o, .mem_size_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ready_i,
    .irq_o, .irq_vec_o, .irq_lvl_o
  );
endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [1:0]  mem_size_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic [31:0] mem_rdata_i,
  input logic        mem_ready_i,
  input logic        irq_o,
  input logic [4:0]  irq_vec_o,
  input logic [2:0]  irq_lvl_o
);
  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_size_o) && $stable(mem_wdata_o)));

  a_r3_write_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && !mem_we_o) |=> (mem_req_o && mem_we_o
      && mem_wdata_o == $past(mem_rdata_i) && mem_size_o == $past(mem_size_o)));

  a_r8_irq_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_lvl_o == 3'd7 && irq_vec_o >= 5'd14 && irq_vec_o <= 5'd17));

  a_r8_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r8_clear_after_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> (mem_req_o && mem_we_o && mem_size_o == 2'd0 && mem_wdata_o == 32'd0
      && mem_addr_o == 32'h7C + 32'($past(irq_vec_o)) - 32'd14));
endmodule

bind dma4_engine dma4_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_size_o(mem_size_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
  .mem_ready_i(mem_ready_i),
  .irq_o(irq_o), .irq_vec_o(irq_vec_o), .irq_lvl_o(irq_lvl_o)
);

// File: tb/dma4_engine_tb.sv
module dma4_engine_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [1:0]  cfg_size = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  trig = '0;
  logic        mem_req, mem_we, mem_ready;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;
  logic [4:0]  irq_vec;
  logic [2:0]  irq_lvl;

  always #4 clk = ~clk;

  dma4_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_size_i(cfg_size),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .trig_i(trig),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready),
    .irq_o(irq), .irq_vec_o(irq_vec), .irq_lvl_o(irq_lvl)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdv(logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  // memory model with programmable wait states
  int wait_n = 1;
  int wcnt = 0;
  always @(posedge clk) begin
    if (!rst_ni) begin
      mem_ready <= 1'b0;
      mem_rdata <= '0;
      wcnt <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
    end else if (mem_req) begin
      if (wcnt >= wait_n) begin
        mem_ready <= 1'b1;
        mem_rdata <= rdv(mem_addr);
        wcnt <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  sz;
    logic        we;
    logic [31:0] data;
    string       tag;
  } bus_t;

  bus_t exp_q[$];
  int   irq_q[$];

  // monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (mem_req && mem_ready) begin : mon_bus
        bus_t e;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 R7 unexpected bus cycle", mem_addr, 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          chk(mem_addr == e.addr && mem_we == e.we && mem_size == e.sz
              && (!e.we || mem_wdata == e.data),
              e.tag, e.we ? mem_wdata : mem_addr, e.we ? e.data : e.addr);
          if (mem_addr != e.addr) $display("  addr actual=%h expected=%h", mem_addr, e.addr);
        end
      end
      if (irq) begin
        if (irq_q.size() == 0) begin
          chk(1'b0, "R8 unexpected interrupt", 32'(irq_vec), 32'hFFFF_FFFF);
        end else begin : mon_irq
          int v;
          v = irq_q.pop_front();
          chk(32'(irq_vec) == 32'(v) && irq_lvl == 3'd7, "R8 interrupt vector/level",
              {24'd0, irq_lvl, irq_vec}, {24'd0, 3'd7, 5'(v)});
        end
      end
    end
  end

  logic [31:0] m_src [4];
  logic [31:0] m_dst [4];
  logic [15:0] m_cnt [4];
  logic [7:0]  m_mode[4];

  task automatic push_unit(int ch, string tg);
    logic [2:0]  md;
    logic [1:0]  sz;
    logic [31:0] step;
    if (m_cnt[ch] == 16'd0) return;
    md = m_mode[ch][4:2];
    sz = m_mode[ch][1:0];
    step = (sz == 2'd3) ? 32'd0 : (32'd1 << sz);
    if (md <= 3'd4 && sz != 2'd3) begin
      exp_q.push_back('{m_src[ch], sz, 1'b0, 32'd0, {tg, " R11 read"}});
      exp_q.push_back('{m_dst[ch], sz, 1'b1, rdv(m_src[ch]), {tg, " R3 copy"}});
    end
    case (md)
      3'd0: m_dst[ch] = m_dst[ch] + step;
      3'd1: m_dst[ch] = m_dst[ch] - step;
      3'd2: m_src[ch] = m_src[ch] + step;
      3'd3: m_src[ch] = m_src[ch] - step;
      3'd5: m_src[ch] = m_src[ch] + 32'd1;
      default: ;
    endcase
    m_cnt[ch] = m_cnt[ch] - 16'd1;
    if (m_cnt[ch] == 16'd0) begin
      exp_q.push_back('{32'h7C + 32'(ch), 2'd0, 1'b1, 32'd0, "R8 vector clear"});
      irq_q.push_back(14 + ch);
    end
  endtask

  task automatic cfg_wr(logic [7:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_size = sz; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [1:0] sz, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_addr = a; cfg_size = sz;
    #1;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic set_ch(int ch, logic [31:0] s, logic [31:0] d, logic [15:0] c, logic [7:0] m);
    cfg_wr(8'(4 * ch), 2'd2, s);
    cfg_wr(8'(16 + 4 * ch), 2'd2, d);
    cfg_wr(8'(32 + 4 * ch), 2'd1, 32'(c));
    cfg_wr(8'(34 + 4 * ch), 2'd0, 32'(m));
    m_src[ch] = s; m_dst[ch] = d; m_cnt[ch] = c; m_mode[ch] = m;
  endtask

  task automatic chk_ch(int ch, string tag);
    rd_chk(8'(4 * ch), 2'd2, m_src[ch], {tag, " src"});
    rd_chk(8'(16 + 4 * ch), 2'd2, m_dst[ch], {tag, " dst"});
    rd_chk(8'(32 + 4 * ch), 2'd1, 32'(m_cnt[ch]), {tag, " count"});
    rd_chk(8'(34 + 4 * ch), 2'd0, 32'(m_mode[ch]), {tag, " mode"});
  endtask

  task automatic pulse(logic [3:0] mask);
    @(negedge clk);
    trig = mask;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while ((exp_q.size() != 0 || irq_q.size() != 0) && k < 2000) begin
      @(negedge clk);
      k++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic run(int ch, int n, string tg);
    for (int i = 0; i < n; i++) begin
      push_unit(ch, tg);
      pulse(4'(1 << ch));
      wait_idle();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_src[c] = '0; m_dst[c] = '0; m_cnt[c] = '0; m_mode[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    #1;
    chk(!mem_req, "R1 mem_req_o low after reset", 32'(mem_req), 32'd0);
    chk(!irq, "R1 irq_o low after reset", 32'(irq), 32'd0);
    for (int c = 0; c < 4; c++) chk_ch(c, "R1 reset");

    // R2 register map
    set_ch(0, 32'hA000_0001, 32'hB000_0001, 16'h0011, 8'h01);
    set_ch(1, 32'hA000_0002, 32'hB000_0002, 16'h0022, 8'h02);
    set_ch(2, 32'hA000_0003, 32'hB000_0003, 16'h0033, 8'h03);
    set_ch(3, 32'hA000_0004, 32'hB000_0004, 16'h0044, 8'h04);
    for (int c = 0; c < 4; c++) chk_ch(c, "R2 map");
    rd_chk(8'h30, 2'd2, 32'd0, "R2 unmapped offset");
    rd_chk(8'h20, 2'd2, 32'd0, "R2 count with long size");
    rd_chk(8'h22, 2'd1, 32'd0, "R2 mode with word size");
    cfg_wr(8'h22, 2'd1, 32'h0000_00FF);
    cfg_wr(8'h01, 2'd0, 32'h0000_00FF);
    cfg_wr(8'h40, 2'd2, 32'hFFFF_FFFF);
    chk_ch(0, "R2 ignored writes");

    // R3 R4 mode 0 byte, three units, last terminal
    set_ch(0, 32'h0000_1000, 32'h0000_2000, 16'd3, 8'h00);
    run(0, 3, "R4 mode0 byte");
    chk_ch(0, "R4 mode0 after");

    // R7 zero count
    pulse(4'b0001);
    wait_idle();
    chk_ch(0, "R7 zero count");

    // R4 mode 1 word
    set_ch(1, 32'h0000_1100, 32'h0000_2100, 16'd2, 8'h05);
    run(1, 2, "R4 mode1 word");
    chk_ch(1, "R4 mode1 after");

    // R5 mode 2 long, mode 3 byte
    set_ch(2, 32'h0000_1200, 32'h0000_2200, 16'd2, 8'h0A);
    run(2, 2, "R5 mode2 long");
    chk_ch(2, "R5 mode2 after");
    set_ch(3, 32'h0000_1300, 32'h0000_2300, 16'd2, 8'h0C);
    run(3, 2, "R5 mode3 byte");
    chk_ch(3, "R5 mode3 after");

    // R6 fixed, counter, size 3, mode 6
    set_ch(0, 32'h0000_1400, 32'h0000_2400, 16'd2, 8'h11);
    run(0, 2, "R6 mode4 fixed");
    chk_ch(0, "R6 mode4 after");
    set_ch(1, 32'h0000_1500, 32'h0000_2500, 16'd2, 8'h14);
    run(1, 2, "R6 mode5 counter");
    chk_ch(1, "R6 mode5 after");
    set_ch(2, 32'h0000_1600, 32'h0000_2600, 16'd1, 8'h03);
    run(2, 1, "R6 size3");
    chk_ch(2, "R6 size3 after");
    set_ch(3, 32'h0000_1700, 32'h0000_2700, 16'd1, 8'h18);
    run(3, 1, "R6 mode6");
    chk_ch(3, "R6 mode6 after");

    // R9 priority and latching: ch1+ch3 together, ch2 arrives while ch1 busy
    wait_n = 2;
    set_ch(1, 32'h0000_5100, 32'h0000_6100, 16'd1, 8'h02);
    set_ch(2, 32'h0000_5200, 32'h0000_6200, 16'd1, 8'h02);
    set_ch(3, 32'h0000_5300, 32'h0000_6300, 16'd1, 8'h02);
    push_unit(1, "R9 first ch1");
    push_unit(2, "R9 latched ch2");
    push_unit(3, "R9 last ch3");
    pulse(4'b1010);
    repeat (2) @(negedge clk);
    pulse(4'b0100);
    wait_idle();
    for (int c = 1; c < 4; c++) chk_ch(c, "R9 after");

    // R10 deferred writes to the channel in flight
    wait_n = 4;
    set_ch(0, 32'h0000_3000, 32'h0000_4000, 16'd5, 8'h02);
    push_unit(0, "R10 old dst used");
    pulse(4'b0001);
    cfg_wr(8'h10, 2'd2, 32'h0000_9000);
    m_dst[0] = 32'h0000_9000;
    wait_idle();
    chk_ch(0, "R10 dst write wins");
    push_unit(0, "R10 second unit");
    pulse(4'b0001);
    cfg_wr(8'h20, 2'd1, 32'd1);
    m_cnt[0] = 16'd1;
    wait_idle();
    chk_ch(0, "R10 count write wins");
    run(0, 1, "R10 R8 terminal after deferred count");
    chk_ch(0, "R10 R8 final");

    chk(exp_q.size() == 0 && irq_q.size() == 0, "R8 all expected activity seen",
        32'(exp_q.size() + irq_q.size()), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule